// File: doc/BRIEF.md
# Ping-Pong Receive DMA Address Generator

This block steers an incoming stream of data words into two memory buffers in turn. Software sets a start index for each buffer, one word count and one signed address step, then turns the channel on. Every accepted word becomes a memory write request carrying the next address. The first buffer always starts at its own index. Once `count` words have gone into one buffer, the channel moves to the start of the other buffer on the very next word. The count reload and the buffer switch happen in hardware, so software never reloads anything.

Each time a buffer fills, the block raises a one-cycle interrupt for that buffer and records which buffer it was. Software can then work on that buffer while the other one fills. The channel has no descriptor chaining: alternating between the two buffers is its only way of carrying on by itself.

The input stream and the memory port both use valid/ready handshakes. A word is taken on a cycle where `s_valid` and `s_ready` are both high. A memory request stays on the port, unchanged, until it is taken on a cycle where `m_valid` and `m_ready` are both high. `s_ready` goes low whenever the channel is off. It also goes low whenever a request is waiting on the memory port and `m_ready` is low. In that way back-pressure from memory passes straight through to the source, and the block never buffers more than one word.

Top module: `pp_dma_agen`

## Requirements
- R1: After reset, and for as long as the channel is off, `s_ready`, `m_valid`, `irq_a`, `irq_b` and `filled_any` are all 0, whatever `s_valid` does.
- R2: A write on the register port (`cfg_we`=1) uses `cfg_sel` to pick the target: 0 = control (bit 0 of the data is enable), 1 = index of buffer A, 2 = index of buffer B, 3 = word count, 4 = signed step.
- R3: A write that turns enable on makes the first accepted word go to the index of buffer A, with the word counter loaded from count.
- R4: Each later word within the same buffer goes to the previous address plus the step. The step is taken as two's complement, and the address wraps modulo 2^ADDR_W.
- R5: The word after the count-th word of a buffer goes to the index of the other buffer, with no idle cycle, and the counter reloads. The channel keeps alternating for as long as it is on. A count of 0 behaves as 1.
- R6: `irq_a` (or `irq_b`) is high for exactly one cycle: the cycle in which the memory request for the last word of buffer A (or B) first appears. In that same cycle `filled_buf` shows that buffer (0 = A, 1 = B) and `filled_any` is 1.
- R7: `s_ready` = enable and (not `m_valid` or `m_ready`). A word accepted on an edge appears on `m_data` in the cycle after that edge, with its value unchanged.
- R8: While `m_valid`=1 and `m_ready`=0, `m_valid`, `m_addr` and `m_data` hold their values.
- R9: A write that clears enable makes `s_ready`, `m_valid` and `filled_any` 0 in the cycle after the write. A request that has not been taken is dropped. The next enable starts again at the index of buffer A with a full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | ADDR_W | Register write data |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Input word ready |
| s_data | input | DATA_W | Input word |
| m_valid | output | 1 | Memory write request valid |
| m_ready | input | 1 | Memory port accepts request |
| m_addr | output | ADDR_W | Memory write address |
| m_data | output | DATA_W | Memory write data |
| irq_a | output | 1 | Buffer A filled, one-cycle pulse |
| irq_b | output | 1 | Buffer B filled, one-cycle pulse |
| filled_buf | output | 1 | Most recently filled buffer (0 = A, 1 = B) |
| filled_any | output | 1 | At least one buffer has filled since enable |

## Verification
The hardest case to reach from the ports is a memory stall that lands on a request which must be held, while the next word is already waiting at the input. The stimulus drops `m_ready` just after the first word of a short buffer is taken. It then holds a second word on `s_valid` for several cycles and checks that the held request is frozen and that the input is refused. Once the stall is released, the following words cross into buffer B. A separate test turns the channel off in the middle of a buffer and back on again, and checks that addressing restarts at buffer A. A table of buffer setups covers a downward step, address wrap, a count of one and a count of zero.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

  typedef enum logic {
    BUF_A = 1'b0,
    BUF_B = 1'b1
  } buf_e;

  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    REG_CTRL   = 3'd0,
    REG_IDX_A  = 3'd1,
    REG_IDX_B  = 3'd2,
    REG_COUNT  = 3'd3,
    REG_MODIFY = 3'd4
  } reg_e;

endpackage

// File: rtl/pp_cfg_regs.sv
module pp_cfg_regs
  import pp_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              en,
  output logic              start,
  output logic              stop,
  output logic [ADDR_W-1:0] idx_a,
  output logic [ADDR_W-1:0] idx_b,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] modify
);

  logic ctrl_wr;

  // R2: control register write decode
  assign ctrl_wr = cfg_we && (cfg_sel == REG_CTRL);
  assign start   = ctrl_wr && cfg_wdata[0] && !en;
  assign stop    = ctrl_wr && !cfg_wdata[0] && en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en     <= 1'b0;
      idx_a  <= '0;
      idx_b  <= '0;
      count  <= '0;
      modify <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        REG_CTRL:   en     <= cfg_wdata[0];
        REG_IDX_A:  idx_a  <= cfg_wdata;
        REG_IDX_B:  idx_b  <= cfg_wdata;
        REG_COUNT:  count  <= cfg_wdata[CNT_W-1:0];
        REG_MODIFY: modify <= cfg_wdata;
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/pp_addr_gen.sv
module pp_addr_gen
  import pp_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  logic [ADDR_W-1:0] idx_a,
  input  logic [ADDR_W-1:0] idx_b,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] modify,
  output logic [ADDR_W-1:0] cur_addr,
  output buf_e              cur_buf,
  output logic              last
);

  logic [CNT_W-1:0] remain;

  // A remaining count of 0 or 1 marks the final word (count 0 acts as 1)
  assign last = (remain <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      remain   <= '0;
      cur_buf  <= BUF_A;
    end else if (start) begin
      cur_addr <= idx_a;
      remain   <= count;
      cur_buf  <= BUF_A;
    end else if (step) begin
      if (last) begin
        cur_buf  <= (cur_buf == BUF_A) ? BUF_B : BUF_A;
        cur_addr <= (cur_buf == BUF_A) ? idx_b : idx_a;
        remain   <= count;
      end else begin
        cur_addr <= cur_addr + modify;
        remain   <= remain - CNT_W'(1);
      end
    end
  end

  assert_buffer_swaps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last && !start) |=> (cur_buf != $past(cur_buf)));

  assert_buffer_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last && !start) |=> $stable(cur_buf));

endmodule

// File: rtl/pp_mem_stage.sv
module pp_mem_stage #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              stop,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              m_ready,
  output logic              s_ready,
  output logic              accept,
  output logic              m_valid,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_data
);

  assign s_ready = en && (!m_valid || m_ready);
  assign accept  = s_valid && s_ready && !stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_addr  <= '0;
      m_data  <= '0;
    end else if (stop || !en) begin
      m_valid <= 1'b0;
    end else if (accept) begin
      m_valid <= 1'b1;
      m_addr  <= addr_in;
      m_data  <= s_data;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && !stop) |=>
      (m_valid && $stable(m_addr) && $stable(m_data)));

  assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!m_valid && !s_ready));

endmodule

// File: rtl/pp_done_flags.sv
module pp_done_flags
  import pp_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       last,
  input  buf_e       cur_buf,
  input  logic       stop,
  output logic [1:0] irq,
  output logic       filled_buf,
  output logic       filled_any
);

  for (genvar b = 0; b < 2; b++) begin : g_irq
    always_ff @(posedge clk) begin
      if (!rst_n) irq[b] <= 1'b0;
      else        irq[b] <= step && last && (cur_buf == buf_e'(b));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || stop) begin
      filled_buf <= 1'b0;
      filled_any <= 1'b0;
    end else if (step && last) begin
      filled_buf <= cur_buf;
      filled_any <= 1'b1;
    end
  end

  assert_one_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq));

  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] |=> !irq[0]);

endmodule

// File: rtl/pp_dma_agen.sv
module pp_dma_agen
  import pp_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_data,
  output logic              irq_a,
  output logic              irq_b,
  output logic              filled_buf,
  output logic              filled_any
);

  logic              en, start, stop, accept, last;
  logic [ADDR_W-1:0] idx_a, idx_b, modify, cur_addr;
  logic [CNT_W-1:0]  count;
  logic [1:0]        irq;
  buf_e              cur_buf;

  pp_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .en(en), .start(start), .stop(stop),
    .idx_a(idx_a), .idx_b(idx_b), .count(count), .modify(modify)
  );

  pp_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_agen (
    .clk(clk), .rst_n(rst_n), .start(start), .step(accept),
    .idx_a(idx_a), .idx_b(idx_b), .count(count), .modify(modify),
    .cur_addr(cur_addr), .cur_buf(cur_buf), .last(last)
  );

  pp_mem_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
    .clk(clk), .rst_n(rst_n), .en(en), .stop(stop), .s_valid(s_valid),
    .s_data(s_data), .addr_in(cur_addr), .m_ready(m_ready),
    .s_ready(s_ready), .accept(accept), .m_valid(m_valid),
    .m_addr(m_addr), .m_data(m_data)
  );

  pp_done_flags i_done (
    .clk(clk), .rst_n(rst_n), .step(accept), .last(last),
    .cur_buf(cur_buf), .stop(stop), .irq(irq),
    .filled_buf(filled_buf), .filled_any(filled_any)
  );

  assign irq_a = irq[0];
  assign irq_b = irq[1];

  assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!m_valid && !irq_a && !irq_b));

  assert_irq_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_a || irq_b) |-> (filled_any && (filled_buf == irq_b)));

endmodule

// File: tb/test_pp_dma_agen.sv
`timescale 1ns/1ps
module test_pp_dma_agen;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic s_valid = 1'b0, m_ready = 1'b1;
  logic [DW-1:0] s_data = '0;
  logic s_ready, m_valid, irq_a, irq_b, filled_buf, filled_any;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;

  pp_dma_agen #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_pp_dma_agen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr),
    .m_data(m_data), .irq_a(irq_a), .irq_b(irq_b),
    .filled_buf(filled_buf), .filled_any(filled_any)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [AW-1:0] b;
    logic [CW-1:0] cnt;
    logic [AW-1:0] mdf;
    logic [7:0]    n;
    logic          gap;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{16'h0100, 16'h0200, 10'd4, 16'h0001, 8'd12, 1'b0},
    '{16'h1000, 16'h2000, 10'd3, 16'hFFFE, 8'd9,  1'b1},
    '{16'h0010, 16'h0020, 10'd1, 16'h0004, 8'd6,  1'b0},
    '{16'hFFFE, 16'h0000, 10'd5, 16'h0001, 8'd10, 1'b1},
    '{16'h0040, 16'h0080, 10'd0, 16'h0008, 8'd4,  1'b0}
  };

  int n_chk = 0, n_fail = 0;

  // model parameters (written by tasks), model state (written by monitor)
  logic [AW-1:0] p_a, p_b, p_mdf;
  int p_cnt;
  int restart_req = 0, restart_seen = 0;
  logic [AW-1:0] e_addr;
  int e_rem, n_seen;
  bit e_buf, e_swapped;
  logic [DW-1:0] e_data;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (restart_req != restart_seen) begin
      restart_seen = restart_req;
      e_addr = p_a; e_rem = (p_cnt == 0) ? 1 : p_cnt;
      e_buf = 1'b0; e_swapped = 1'b0; e_data = '0; n_seen = 0;
    end else if (rst_n && m_valid && m_ready) begin
      automatic bit lst = (e_rem == 1);
      automatic string tag = (n_seen == 0) ? "R3" : (e_swapped ? "R5" : "R4");
      check(m_addr == e_addr, tag, "m_addr", m_addr, e_addr);
      check(m_data == e_data, "R7", "m_data", m_data, e_data);
      check({irq_b, irq_a} == {lst && e_buf, lst && !e_buf}, "R6", "irq",
            {irq_b, irq_a}, {lst && e_buf, lst && !e_buf});
      if (lst) check(filled_any && filled_buf == e_buf, "R6", "filled",
                     {filled_any, filled_buf}, {1'b1, e_buf});
      if (lst) begin
        e_buf = !e_buf; e_addr = e_buf ? p_b : p_a;
        e_rem = (p_cnt == 0) ? 1 : p_cnt; e_swapped = 1'b1;
      end else begin
        e_addr = e_addr + p_mdf; e_rem--; e_swapped = 1'b0;
      end
      e_data++; n_seen++;
    end
  end

  // R2: register map 0 ctrl, 1 index A, 2 index B, 3 count, 4 step
  task automatic cfg(input logic [2:0] sel, input logic [AW-1:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [AW-1:0] a, input logic [AW-1:0] b,
                       input int cnt, input logic [AW-1:0] mdf);
    cfg(3'd0, 16'h0000);
    p_a = a; p_b = b; p_cnt = cnt; p_mdf = mdf;
    restart_req++;
    cfg(3'd1, a); cfg(3'd2, b); cfg(3'd3, AW'(cnt)); cfg(3'd4, mdf);
    cfg(3'd0, 16'h0001);
  endtask

  task automatic push(input int k, input bit gap);
    bit acc;
    s_valid = 1'b1; s_data = DW'(k);
    do begin
      @(negedge clk); acc = s_ready;
      @(posedge clk); #1;
    end while (!acc);
    s_valid = 1'b0;
    if (gap) begin @(posedge clk); #1; end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    // R1: idle after reset, input offered but refused
    s_valid = 1'b1;
    repeat (5) @(negedge clk);
    check({s_ready, m_valid, irq_a, irq_b, filled_any} == 5'b0, "R1",
          "idle outputs", {s_ready, m_valid, irq_a, irq_b, filled_any}, 0);
    @(posedge clk); #1; s_valid = 1'b0;

    // table of buffer setups, one loop
    for (int v = 0; v < 5; v++) begin
      setup(VECS[v].a, VECS[v].b, int'(VECS[v].cnt), VECS[v].mdf);
      for (int k = 0; k < int'(VECS[v].n); k++) push(k, VECS[v].gap);
      repeat (3) @(negedge clk);
      check(n_seen == int'(VECS[v].n), "R5", "writes seen", n_seen, VECS[v].n);
      check(!irq_a && !irq_b, "R6", "irq after run", {irq_b, irq_a}, 0);
    end

    // R8/R7: memory stall with next word waiting
    setup(16'h0300, 16'h0400, 2, 16'h0001);
    m_ready = 1'b0;
    push(0, 1'b0);
    s_valid = 1'b1; s_data = 1;
    repeat (3) @(negedge clk);
    check(!s_ready, "R7", "s_ready in stall", s_ready, 0);
    check(m_valid && m_addr == 16'h0300 && m_data == 0, "R8", "held request",
          {m_valid, m_addr}, {1'b1, 16'h0300});
    @(posedge clk); #1; m_ready = 1'b1;
    push(1, 1'b0); push(2, 1'b0); push(3, 1'b0); push(4, 1'b0);
    repeat (3) @(negedge clk);
    check(n_seen == 5, "R5", "writes after stall", n_seen, 5);

    // R9: turn off mid-buffer, then restart at buffer A
    cfg(3'd0, 16'h0000);
    @(negedge clk);
    check({s_ready, m_valid, filled_any} == 3'b0, "R9", "after disable",
          {s_ready, m_valid, filled_any}, 0);
    restart_req++;
    cfg(3'd0, 16'h0001);
    push(0, 1'b0); push(1, 1'b0); push(2, 1'b0);
    repeat (3) @(negedge clk);
    check(n_seen == 3, "R9", "writes after restart", n_seen, 3);

    summary();
  end

endmodule